// File: doc/BRIEF.md
# Flag-Generating Add/Subtract Unit

This block is a purely combinational integer adder/subtractor of configurable width. Alongside the result word it reports four condition flags: carry, signed overflow, negative and zero. Four operations are offered: plain add, add with an incoming carry, plain subtract, and subtract with an incoming borrow. The two carry-chained forms let software build wide arithmetic out of several narrow steps.

Subtraction is formed as A plus the inverted B plus a carry-in. A convention input selects how the carry flag reads after a subtract. In borrow mode a set carry flag means a borrow occurred. In no-borrow mode a set carry flag means no borrow occurred. The same convention also governs how the incoming flag is read by subtract-with-borrow. Signed overflow comes from the two carries at the sign position.

Every output follows its inputs in the same evaluation, with no register or handshake in the path. Operands and control are therefore plain pins, and the block has no back-pressure. A caller that wants registered flags keeps them outside.

Top module: `flagged_addsub`

## Requirements
- R1: With op_i = 2'b00 (add), result_o equals (A + B) mod 2^WIDTH and carry_o is 1 exactly when the unsigned sum exceeds 2^WIDTH - 1.
- R2: With op_i = 2'b01 (add with carry), result_o equals (A + B + carry_i) mod 2^WIDTH and carry_o is 1 exactly when that unsigned sum exceeds 2^WIDTH - 1.
- R3: ovf_o is 1 exactly when the signed (two's complement) value of the operation falls outside [-2^(WIDTH-1), 2^(WIDTH-1) - 1]. An add or add-with-carry of operands whose sign bits differ never raises ovf_o.
- R4: With op_i = 2'b10 (subtract) and no_borrow_i = 0, result_o equals (A - B) mod 2^WIDTH and carry_o is 1 exactly when A < B unsigned.
- R5: With op_i = 2'b10 and no_borrow_i = 1, result_o equals (A - B) mod 2^WIDTH and carry_o is 1 exactly when A >= B unsigned.
- R6: With op_i = 2'b11 (subtract with borrow) and no_borrow_i = 0, carry_i is read as a pending borrow. result_o equals (A - B - carry_i) mod 2^WIDTH and carry_o is 1 exactly when A < B + carry_i.
- R7: With op_i = 2'b11 and no_borrow_i = 1, carry_i is read as "no borrow pending". result_o equals (A - B - (1 - carry_i)) mod 2^WIDTH and carry_o is 1 exactly when A >= B + (1 - carry_i).
- R8: neg_o equals the most significant bit of result_o, and zero_o is 1 exactly when every bit of result_o is 0.
- R9: For add and add-with-carry, no_borrow_i has no effect on any output.
- R10: At WIDTH = 8: 0xFF + 0x01 gives 0x00 with carry 1 and overflow 0. 0x7F + 0x01 gives 0x80 with overflow 1 and carry 0. 0xB4 + 0x9A gives 0x4E with overflow 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | WIDTH | Operand A |
| opb_i | input | WIDTH | Operand B |
| op_i | input | 2 | Operation: 00 add, 01 add with carry, 10 subtract, 11 subtract with borrow |
| carry_i | input | 1 | Incoming carry/borrow flag for the chained forms |
| no_borrow_i | input | 1 | Subtract carry convention: 0 carry means borrow, 1 carry means no borrow |
| result_o | output | WIDTH | Arithmetic result |
| carry_o | output | 1 | Carry flag in the selected convention |
| ovf_o | output | 1 | Signed overflow flag |
| neg_o | output | 1 | Sign of the result |
| zero_o | output | 1 | Result is all zeros |

## Verification
The hardest case to reach is subtract-with-borrow under each convention at its edges. One example is A equal to B with an incoming borrow, where the result wraps to all ones and the carry flag must flip with the convention. Another is the most negative operand minus one, which must overflow. A narrow four-bit instance is swept over every operand pair, every operation, both carry-in values and both conventions, so all of these edge cases are reached. Expected values come from integer arithmetic on the true signed and unsigned values. A second eight-bit instance confirms the fixed examples.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_ADC = 2'b01,
    OP_SUB = 2'b10,
    OP_SBB = 2'b11
  } alu_op_e;

endpackage

// File: rtl/addsub_operand_prep.sv
// Conditions operand B and the adder carry-in for the selected operation.
module addsub_operand_prep
  import addsub_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  alu_op_e            op,
  input  logic [WIDTH-1:0]   opb,
  input  logic               flag_in,
  input  logic               no_borrow,
  output logic [WIDTH-1:0]   opb_eff,
  output logic               cin_eff,
  output logic               is_sub
);

  logic flag_as_carry;

  // Under borrow convention a set flag means "borrow pending", so the
  // adder needs its inverse as the carry-in of A + ~B + cin.
  assign flag_as_carry = no_borrow ? flag_in : ~flag_in;

  always_comb begin
    is_sub  = 1'b0;
    opb_eff = opb;
    cin_eff = 1'b0;
    unique case (op)
      OP_ADD: begin
        cin_eff = 1'b0;
      end
      OP_ADC: begin
        cin_eff = flag_in;
      end
      OP_SUB: begin
        is_sub  = 1'b1;
        opb_eff = ~opb;
        cin_eff = 1'b1;
      end
      OP_SBB: begin
        is_sub  = 1'b1;
        opb_eff = ~opb;
        cin_eff = flag_as_carry;
      end
      default: begin
        cin_eff = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/addsub_ripple.sv
// Ripple-carry adder exposing the carries on both sides of the sign bit.
module addsub_ripple #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             c_msb_in,
  output logic             c_msb_out
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] chain;

  assign chain[0] = cin;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic p;
    logic g;
    assign p            = a[i] ^ b[i];
    assign g            = a[i] & b[i];
    assign sum[i]       = p ^ chain[i];
    assign chain[i+1]   = g | (p & chain[i]);
  end

  assign c_msb_in  = chain[MSB];
  assign c_msb_out = chain[WIDTH];

endmodule

// File: rtl/addsub_flags.sv
// Derives the condition flags from the adder outputs.
module addsub_flags #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] sum,
  input  logic             c_msb_in,
  input  logic             c_msb_out,
  input  logic             is_sub,
  input  logic             no_borrow,
  output logic             carry,
  output logic             ovf,
  output logic             neg,
  output logic             zero
);

  localparam int MSB = WIDTH - 1;

  logic invert_carry;

  // A subtract's raw carry-out already means "no borrow"; flip it only
  // when the borrow convention is selected.
  assign invert_carry = is_sub & ~no_borrow;
  assign carry        = c_msb_out ^ invert_carry;
  assign ovf          = c_msb_in ^ c_msb_out;
  assign neg          = sum[MSB];
  assign zero         = ~|sum;

endmodule

// File: rtl/flagged_addsub.sv
module flagged_addsub
  import addsub_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  input  logic [1:0]       op_i,
  input  logic             carry_i,
  input  logic             no_borrow_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o,
  output logic             ovf_o,
  output logic             neg_o,
  output logic             zero_o
);

  alu_op_e          op;
  logic [WIDTH-1:0] opb_eff;
  logic             cin_eff;
  logic             is_sub;
  logic [WIDTH-1:0] sum;
  logic             c_msb_in;
  logic             c_msb_out;

  assign op = alu_op_e'(op_i);

  addsub_operand_prep #(.WIDTH(WIDTH)) u_prep (
    .op        (op),
    .opb       (opb_i),
    .flag_in   (carry_i),
    .no_borrow (no_borrow_i),
    .opb_eff   (opb_eff),
    .cin_eff   (cin_eff),
    .is_sub    (is_sub)
  );

  addsub_ripple #(.WIDTH(WIDTH)) u_add (
    .a         (opa_i),
    .b         (opb_eff),
    .cin       (cin_eff),
    .sum       (sum),
    .c_msb_in  (c_msb_in),
    .c_msb_out (c_msb_out)
  );

  addsub_flags #(.WIDTH(WIDTH)) u_flags (
    .sum       (sum),
    .c_msb_in  (c_msb_in),
    .c_msb_out (c_msb_out),
    .is_sub    (is_sub),
    .no_borrow (no_borrow_i),
    .carry     (carry_o),
    .ovf       (ovf_o),
    .neg       (neg_o),
    .zero      (zero_o)
  );

  assign result_o = sum;

endmodule

// File: rtl/addsub_checker.sv
module addsub_checker #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] opa_i,
  input logic [WIDTH-1:0] opb_i,
  input logic [1:0]       op_i,
  input logic             carry_i,
  input logic             no_borrow_i,
  input logic [WIDTH-1:0] result_o,
  input logic             carry_o,
  input logic             ovf_o,
  input logic             neg_o,
  input logic             zero_o
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] wide_sum;
  logic           is_addish;

  assign wide_sum  = {1'b0, opa_i} + {1'b0, opb_i} + {{WIDTH{1'b0}}, (op_i == 2'b01) & carry_i};
  assign is_addish = ~op_i[1];

  always_comb begin
    if (is_addish && (opa_i[MSB] != opb_i[MSB]))
      AST_NO_OVF_MIXED_SIGN: assert (!ovf_o) else $error("overflow on mixed-sign add"); // R3
    if (is_addish && (opa_i[MSB] == opb_i[MSB]))
      AST_OVF_SIGN_FLIP: assert (ovf_o == (result_o[MSB] != opa_i[MSB])) else $error("overflow vs sign flip"); // R3
    if (is_addish)
      AST_ADD_CARRY: assert (carry_o == wide_sum[WIDTH]) else $error("add carry mismatch"); // R1
    if (op_i == 2'b10 && !no_borrow_i)
      AST_SUB_BORROW: assert (carry_o == (opa_i < opb_i)) else $error("borrow-mode carry"); // R4
    if (op_i == 2'b10 && no_borrow_i)
      AST_SUB_NO_BORROW: assert (carry_o == (opa_i >= opb_i)) else $error("no-borrow-mode carry"); // R5
    AST_NEG_IS_MSB: assert (neg_o == result_o[MSB]) else $error("negative flag"); // R8
    AST_ZERO_FLAG: assert (zero_o == (result_o == '0)) else $error("zero flag"); // R8
  end

endmodule

bind flagged_addsub addsub_checker #(.WIDTH(WIDTH)) u_chk (
  .opa_i       (opa_i),
  .opb_i       (opb_i),
  .op_i        (op_i),
  .carry_i     (carry_i),
  .no_borrow_i (no_borrow_i),
  .result_o    (result_o),
  .carry_o     (carry_o),
  .ovf_o       (ovf_o),
  .neg_o       (neg_o),
  .zero_o      (zero_o)
);

// File: tb/tb_flagged_addsub.sv
module tb_flagged_addsub;

  localparam int W  = 4;
  localparam int W8 = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [W-1:0] a, b;
  logic [1:0]   op;
  logic         cin, nb;
  logic [W-1:0] res;
  logic         c_o, v_o, n_o, z_o;

  logic [W8-1:0] a8, b8;
  logic [1:0]    op8;
  logic          cin8, nb8;
  logic [W8-1:0] res8;
  logic          c8, v8, n8, z8;

  flagged_addsub #(.WIDTH(W)) dut (
    .opa_i(a), .opb_i(b), .op_i(op), .carry_i(cin), .no_borrow_i(nb),
    .result_o(res), .carry_o(c_o), .ovf_o(v_o), .neg_o(n_o), .zero_o(z_o)
  );

  flagged_addsub #(.WIDTH(W8)) dut_w8 (
    .opa_i(a8), .opb_i(b8), .op_i(op8), .carry_i(cin8), .no_borrow_i(nb8),
    .result_o(res8), .carry_o(c8), .ovf_o(v8), .neg_o(n8), .zero_o(z8)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input int ia, input int ib, input int iop, input int ic, input int inb);
    int sa, sb, ur, sr, lim;
    bit exp_c, exp_v;
    logic [W-1:0] exp_r;
    string tag;
    @(posedge clk);
    a = W'(ia); b = W'(ib); op = 2'(iop); cin = ic[0]; nb = inb[0];
    lim = 1 << W;
    sa = (ia >= lim/2) ? ia - lim : ia;
    sb = (ib >= lim/2) ? ib - lim : ib;
    case (iop)
      0: begin ur = ia + ib;      sr = sa + sb;      tag = (inb != 0) ? "R1/R9" : "R1"; end
      1: begin ur = ia + ib + ic; sr = sa + sb + ic; tag = (inb != 0) ? "R2/R9" : "R2"; end
      2: begin ur = ia - ib;      sr = sa - sb;      tag = (inb != 0) ? "R5" : "R4"; end
      default: begin
        if (inb != 0) begin ur = ia - ib - (1 - ic); sr = sa - sb - (1 - ic); tag = "R7"; end
        else begin ur = ia - ib - ic; sr = sa - sb - ic; tag = "R6"; end
      end
    endcase
    exp_r = W'(ur);
    if (iop < 2) exp_c = (ur >= lim);
    else if (inb != 0) exp_c = (ur >= 0);
    else exp_c = (ur < 0);
    exp_v = (sr > lim/2 - 1) || (sr < -(lim/2));
    @(negedge clk);
    check(res == exp_r && c_o == exp_c, tag, {res, c_o}, {exp_r, exp_c});
    check(v_o == exp_v, "R3", v_o, exp_v);
    check(n_o == exp_r[W-1] && z_o == (exp_r == '0), "R8", {n_o, z_o}, {exp_r[W-1], exp_r == '0});
  endtask

  task automatic run_w8(input logic [7:0] ia, input logic [7:0] ib,
                        input logic [7:0] er, input bit ec, input bit ev, input bit chk_c);
    @(posedge clk);
    a8 = ia; b8 = ib; op8 = 2'b00; cin8 = 1'b0; nb8 = 1'b0;
    @(negedge clk);
    check(res8 == er, "R10 result", res8, er);
    check(v8 == ev, "R10 overflow", v8, ev);
    if (chk_c) check(c8 == ec, "R10 carry", c8, ec);
  endtask

  initial begin
    a = '0; b = '0; op = '0; cin = 1'b0; nb = 1'b0;
    a8 = '0; b8 = '0; op8 = '0; cin8 = 1'b0; nb8 = 1'b0;
    @(negedge clk);
    // Idle state with zero operands: add of zeros is zero, no flags (R8, R1)
    check(res == '0 && z_o && !c_o && !v_o && !n_o, "R8 idle", {res, z_o, c_o, v_o, n_o}, 5'b00001_0000 >> 4);
    run_w8(8'hFF, 8'h01, 8'h00, 1'b1, 1'b0, 1'b1);
    run_w8(8'h7F, 8'h01, 8'h80, 1'b0, 1'b1, 1'b1);
    run_w8(8'hB4, 8'h9A, 8'h4E, 1'b1, 1'b1, 1'b0);
    for (int o = 0; o < 4; o++)
      for (int m = 0; m < 2; m++)
        for (int c = 0; c < 2; c++)
          for (int x = 0; x < (1 << W); x++)
            for (int y = 0; y < (1 << W); y++)
              run_vec(x, y, o, c, m);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule